// File: doc/BRIEF.md
# Host Byte Mailbox with Coherent Status

This block lets an external host, clocked separately from a signal-processing core, pass 16-bit words to and from that core one byte at a time. The host starts each access with an enable strobe. A two-bit select and a read or write qualifier travel with the strobe. Two data selects reach a high byte and a low byte. When written, they form the outbound word. When read, they return the inbound word. A third select returns an 8-bit status byte.

Every value that crosses between the clocks goes through a toggle handshake and a multi-flop synchronizer. The core drives two user flags, and they cross as one registered pair, so the host only ever sees a pair value that the core actually presented. The status byte is captured once, at the start of a strobe, and held for as long as the strobe lasts. A slow host read therefore returns a single coherent sample.

The core side uses simple valid/take and load/free signalling. Words from the host arrive on `c_rx_word` and are marked by `c_rx_valid`. Words for the host are offered on `c_tx_word` with `c_tx_load`, and the core may load a word only while `c_tx_free` is high.

Top module: `hbm_port`

## Requirements
- R1: After reset the status byte reads 0x02, `c_tx_free` is 1 and `c_rx_valid` is 0.
- R2: The status byte has this layout: bit0 is receive-full, bit1 is transmit-empty, bit2 is user flag 0, bit3 is user flag 1, bit7 is the sticky overrun bit, and all other bits are 0. A status read returns the value captured on the first host clock edge of the strobe, and that value does not change for the rest of the strobe.
- R3: The host writes the high byte with select 1, then the low byte with select 2, while transmit-empty is 1. The low-byte write clears transmit-empty. After the synchronizer delay, `c_rx_valid` rises with `c_rx_word` equal to {high, low}.
- R4: A write to select 1 or select 2 while transmit-empty is 0 has no effect on the data path. It sets the overrun bit, and that bit stays set until reset.
- R5: Transmit-empty becomes 1 again after the core pulses `c_rx_take` while `c_rx_valid` is high.
- R6: A `c_tx_load` while `c_tx_free` is 1 clears `c_tx_free`. It later sets receive-full, and the host then reads the word's high byte at select 1 and its low byte at select 2.
- R7: A read strobe on select 2 clears receive-full when the strobe ends, and `c_tx_free` then returns to 1. A `c_tx_load` while `c_tx_free` is 0 is ignored.
- R8: The host-visible flag pair always equals a value the core held for a full core cycle. If the core flips the pair between 00 and 11 every cycle, no status read shows 01 or 10.
- R9: While `c_rx_valid` is high and `c_rx_take` is low, `c_rx_valid` stays high and `c_rx_word` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk | input | 1 | Host-side clock |
| h_rst_n | input | 1 | Host-side reset, active low |
| h_en | input | 1 | Host access strobe |
| h_rd | input | 1 | Read qualifier for the strobe |
| h_wr | input | 1 | Write qualifier for the strobe |
| h_sel | input | 2 | 0 status, 1 high byte, 2 low byte |
| h_wdata | input | BYTE_W | Host write byte |
| h_rdata | output | BYTE_W | Host read byte, 0 when not strobed |
| c_clk | input | 1 | Core clock |
| c_rst_n | input | 1 | Core reset, active low |
| c_flags | input | 2 | User flag pair {flag1, flag0} |
| c_rx_word | output | 2*BYTE_W | Word received from the host |
| c_rx_valid | output | 1 | Received word present |
| c_rx_take | input | 1 | Core consumes the received word |
| c_tx_word | input | 2*BYTE_W | Word offered to the host |
| c_tx_load | input | 1 | Load `c_tx_word` |
| c_tx_free | output | 1 | Outbound slot is free |

## Verification
The case that is hardest to reach is a host strobe that lands while the flag pair is in mid-crossing. The bench handles it by flipping the core's flag pair between 00 and 11 on every core cycle, with a core clock period that is unrelated to the host clock. While this runs, it makes hundreds of status reads. Some of those strobes are sampled several times, which checks both that the pair value is legal and that the snapshot holds across the strobe. A further stimulus drives a second load and a second write while the first handshake is still in flight, so that both ignored-access paths are exercised.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_LO   = 2'd2;

  localparam int ST_RXF = 0;
  localparam int ST_TXE = 1;
  localparam int ST_F0  = 2;
  localparam int ST_F1  = 3;
  localparam int ST_OVR = 7;

  function automatic logic [7:0] pack_status(input logic rxf, input logic txe,
                                             input logic [1:0] fl, input logic ovr);
    logic [7:0] s;
    s = '0;
    s[ST_RXF] = rxf;
    s[ST_TXE] = txe;
    s[ST_F0]  = fl[0];
    s[ST_F1]  = fl[1];
    s[ST_OVR] = ovr;
    return s;
  endfunction
endpackage

// File: rtl/hbm_sync.sv
module hbm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbm_core_regs.sv
module hbm_core_regs #(
  parameter int BYTE_W = 8
) (
  input  logic                  c_clk,
  input  logic                  c_rst_n,
  input  logic [1:0]            c_flags,
  input  logic                  c_rx_take,
  input  logic                  c_tx_load,
  input  logic [2*BYTE_W-1:0]   c_tx_word,
  input  logic [2*BYTE_W-1:0]   h_tx_word,
  input  logic                  tx_tog_s,
  input  logic                  done_tog_s,
  input  logic                  fl_ack_s,
  output logic [2*BYTE_W-1:0]   c_rx_word,
  output logic                  c_rx_valid,
  output logic                  c_tx_free,
  output logic [2*BYTE_W-1:0]   c_tx_hold,
  output logic                  dat_tog,
  output logic                  ack_tog,
  output logic [1:0]            flag_hold,
  output logic                  fl_req
);
  logic [1:0] flag_q;
  logic       tx_seen, done_seen;
  logic       word_arrive, take_ev, load_ev, freed, fl_idle;

  assign word_arrive = tx_tog_s != tx_seen;
  assign take_ev     = c_rx_valid & c_rx_take;
  assign load_ev     = c_tx_load & c_tx_free;
  assign freed       = done_tog_s != done_seen;
  assign fl_idle     = fl_ack_s == fl_req;

  always_ff @(posedge c_clk or negedge c_rst_n) begin
    if (!c_rst_n) begin
      flag_q     <= '0;
      flag_hold  <= '0;
      fl_req     <= 1'b0;
      c_rx_word  <= '0;
      c_rx_valid <= 1'b0;
      tx_seen    <= 1'b0;
      ack_tog    <= 1'b0;
      c_tx_hold  <= '0;
      dat_tog    <= 1'b0;
      c_tx_free  <= 1'b1;
      done_seen  <= 1'b0;
    end else begin
      flag_q <= c_flags;
      if (fl_idle) begin
        flag_hold <= flag_q;
        fl_req    <= ~fl_req;
      end
      if (word_arrive) begin
        c_rx_word  <= h_tx_word;
        c_rx_valid <= 1'b1;
        tx_seen    <= tx_tog_s;
      end
      if (take_ev) begin
        c_rx_valid <= 1'b0;
        ack_tog    <= ~ack_tog;
      end
      if (freed) begin
        c_tx_free <= 1'b1;
        done_seen <= done_tog_s;
      end
      if (load_ev) begin
        c_tx_hold <= c_tx_word;
        dat_tog   <= ~dat_tog;
        c_tx_free <= 1'b0;
      end
    end
  end

  // R9: a pending word is held until the core takes it
  p_rx_hold_r9: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    (c_rx_valid && !c_rx_take) |=> (c_rx_valid && $stable(c_rx_word)));
  // R7: a load while the slot is busy leaves the outbound word alone
  p_load_ignored_r7: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    (c_tx_load && !c_tx_free) |=> $stable(c_tx_hold));
  // R8: the pair offered to the host is frozen while a crossing is in flight
  p_flag_frozen_r8: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    !fl_idle |=> $stable(flag_hold));
endmodule

// File: rtl/hbm_host_regs.sv
module hbm_host_regs #(
  parameter int BYTE_W = 8
) (
  input  logic                  h_clk,
  input  logic                  h_rst_n,
  input  logic                  h_en,
  input  logic                  h_rd,
  input  logic                  h_wr,
  input  logic [1:0]            h_sel,
  input  logic [BYTE_W-1:0]     h_wdata,
  output logic [BYTE_W-1:0]     h_rdata,
  output logic [2*BYTE_W-1:0]   tx_word,
  output logic                  tx_tog,
  input  logic                  ack_tog_s,
  input  logic [2*BYTE_W-1:0]   c_tx_hold,
  input  logic                  dat_tog_s,
  output logic                  done_tog,
  input  logic [1:0]            flag_hold,
  input  logic                  fl_req_s,
  output logic                  fl_ack
);
  import hbm_pkg::*;
  localparam int WORD_W = 2 * BYTE_W;

  logic              en_q, rd_q, txe, rxf, ovr;
  logic [1:0]        sel_q, flags;
  logic [BYTE_W-1:0] tx_hi;
  logic [WORD_W-1:0] rx_word;
  logic [7:0]        snap, live;
  logic              dat_seen, ack_seen;
  logic              strobe_rise, strobe_fall, wr_hi_ev, wr_lo_ev, wr_blocked;
  logic              rd_lo_done, word_in, word_acked, flag_in;

  assign strobe_rise = h_en & ~en_q;
  assign strobe_fall = ~h_en & en_q;
  assign live        = pack_status(rxf, txe, flags, ovr);
  assign wr_hi_ev    = strobe_rise & h_wr & (h_sel == SEL_HI);
  assign wr_lo_ev    = strobe_rise & h_wr & (h_sel == SEL_LO);
  assign wr_blocked  = (wr_hi_ev | wr_lo_ev) & ~txe;
  assign rd_lo_done  = strobe_fall & rd_q & (sel_q == SEL_LO) & rxf;
  assign word_in     = dat_tog_s != dat_seen;
  assign word_acked  = ack_tog_s != ack_seen;
  assign flag_in     = fl_req_s != fl_ack;

  always_ff @(posedge h_clk or negedge h_rst_n) begin
    if (!h_rst_n) begin
      en_q     <= 1'b0;
      sel_q    <= '0;
      rd_q     <= 1'b0;
      snap     <= '0;
      txe      <= 1'b1;
      rxf      <= 1'b0;
      ovr      <= 1'b0;
      flags    <= '0;
      tx_hi    <= '0;
      tx_word  <= '0;
      tx_tog   <= 1'b0;
      ack_seen <= 1'b0;
      rx_word  <= '0;
      dat_seen <= 1'b0;
      done_tog <= 1'b0;
      fl_ack   <= 1'b0;
    end else begin
      en_q <= h_en;
      if (strobe_rise) begin
        sel_q <= h_sel;
        rd_q  <= h_rd;
        snap  <= live;
      end
      if (wr_blocked) ovr <= 1'b1;
      if (wr_hi_ev && txe) tx_hi <= h_wdata;
      if (word_acked) begin
        txe      <= 1'b1;
        ack_seen <= ack_tog_s;
      end
      if (wr_lo_ev && txe) begin
        tx_word <= {tx_hi, h_wdata};
        tx_tog  <= ~tx_tog;
        txe     <= 1'b0;
      end
      if (word_in) begin
        rx_word  <= c_tx_hold;
        rxf      <= 1'b1;
        dat_seen <= dat_tog_s;
      end
      if (rd_lo_done) begin
        rxf      <= 1'b0;
        done_tog <= ~done_tog;
      end
      if (flag_in) begin
        flags  <= flag_hold;
        fl_ack <= fl_req_s;
      end
    end
  end

  always_comb begin
    h_rdata = '0;
    if (h_en) begin
      case (h_sel)
        SEL_STAT: h_rdata = BYTE_W'(snap);
        SEL_HI:   h_rdata = rx_word[WORD_W-1:BYTE_W];
        SEL_LO:   h_rdata = rx_word[BYTE_W-1:0];
        default:  h_rdata = '0;
      endcase
    end
  end

  // R2: the captured status does not move during a held strobe
  p_snap_hold_r2: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    (h_en && en_q) |=> $stable(snap));
  // R3: an accepted low-byte write empties the transmit slot
  p_txe_clear_r3: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    (wr_lo_ev && txe) |=> !txe);
  // R4: overrun never clears once set
  p_ovr_sticky_r4: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    ovr |=> ovr);
  // R7: finishing a low-byte read drops receive-full
  p_rxf_clear_r7: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    rd_lo_done |=> !rxf);
  // R8: the host pair is copied whole from the core's frozen pair
  p_flag_pair_r8: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    flag_in |=> (flags == $past(flag_hold)));
endmodule

// File: rtl/hbm_port.sv
module hbm_port #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  h_clk,
  input  logic                  h_rst_n,
  input  logic                  h_en,
  input  logic                  h_rd,
  input  logic                  h_wr,
  input  logic [1:0]            h_sel,
  input  logic [BYTE_W-1:0]     h_wdata,
  output logic [BYTE_W-1:0]     h_rdata,
  input  logic                  c_clk,
  input  logic                  c_rst_n,
  input  logic [1:0]            c_flags,
  output logic [2*BYTE_W-1:0]   c_rx_word,
  output logic                  c_rx_valid,
  input  logic                  c_rx_take,
  input  logic [2*BYTE_W-1:0]   c_tx_word,
  input  logic                  c_tx_load,
  output logic                  c_tx_free
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] tx_word, c_tx_hold;
  logic [1:0]        flag_hold;
  logic tx_tog, tx_tog_s, done_tog, done_tog_s, fl_ack, fl_ack_s;
  logic ack_tog, ack_tog_s, dat_tog, dat_tog_s, fl_req, fl_req_s;

  hbm_sync #(.STAGES(SYNC_STAGES)) u_s_tx   (.clk(c_clk), .rst_n(c_rst_n), .d(tx_tog),   .q(tx_tog_s));
  hbm_sync #(.STAGES(SYNC_STAGES)) u_s_done (.clk(c_clk), .rst_n(c_rst_n), .d(done_tog), .q(done_tog_s));
  hbm_sync #(.STAGES(SYNC_STAGES)) u_s_fack (.clk(c_clk), .rst_n(c_rst_n), .d(fl_ack),   .q(fl_ack_s));
  hbm_sync #(.STAGES(SYNC_STAGES)) u_s_ack  (.clk(h_clk), .rst_n(h_rst_n), .d(ack_tog),  .q(ack_tog_s));
  hbm_sync #(.STAGES(SYNC_STAGES)) u_s_dat  (.clk(h_clk), .rst_n(h_rst_n), .d(dat_tog),  .q(dat_tog_s));
  hbm_sync #(.STAGES(SYNC_STAGES)) u_s_freq (.clk(h_clk), .rst_n(h_rst_n), .d(fl_req),   .q(fl_req_s));

  hbm_host_regs #(.BYTE_W(BYTE_W)) u_host (
    .h_clk(h_clk), .h_rst_n(h_rst_n), .h_en(h_en), .h_rd(h_rd), .h_wr(h_wr),
    .h_sel(h_sel), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .tx_word(tx_word), .tx_tog(tx_tog), .ack_tog_s(ack_tog_s),
    .c_tx_hold(c_tx_hold), .dat_tog_s(dat_tog_s), .done_tog(done_tog),
    .flag_hold(flag_hold), .fl_req_s(fl_req_s), .fl_ack(fl_ack)
  );

  hbm_core_regs #(.BYTE_W(BYTE_W)) u_core (
    .c_clk(c_clk), .c_rst_n(c_rst_n), .c_flags(c_flags), .c_rx_take(c_rx_take),
    .c_tx_load(c_tx_load), .c_tx_word(c_tx_word), .h_tx_word(tx_word),
    .tx_tog_s(tx_tog_s), .done_tog_s(done_tog_s), .fl_ack_s(fl_ack_s),
    .c_rx_word(c_rx_word), .c_rx_valid(c_rx_valid), .c_tx_free(c_tx_free),
    .c_tx_hold(c_tx_hold), .dat_tog(dat_tog), .ack_tog(ack_tog),
    .flag_hold(flag_hold), .fl_req(fl_req)
  );
endmodule

// File: tb/hbm_port_bench.sv
module hbm_port_bench;
  logic        h_clk = 0, c_clk = 0, h_rst_n = 0, c_rst_n = 0;
  logic        h_en = 0, h_rd = 0, h_wr = 0;
  logic [1:0]  h_sel = 0;
  logic [7:0]  h_wdata = 0, h_rdata;
  logic [1:0]  c_flags = 0;
  logic [15:0] c_rx_word, c_tx_word = 0;
  logic        c_rx_valid, c_rx_take = 0, c_tx_load = 0, c_tx_free;
  logic        flip_on = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  bit ovr_exp = 0;

  always #5 h_clk = ~h_clk;
  always #3.65 c_clk = ~c_clk;

  hbm_port u_hbm_port (
    .h_clk(h_clk), .h_rst_n(h_rst_n), .h_en(h_en), .h_rd(h_rd), .h_wr(h_wr),
    .h_sel(h_sel), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .c_clk(c_clk), .c_rst_n(c_rst_n), .c_flags(c_flags),
    .c_rx_word(c_rx_word), .c_rx_valid(c_rx_valid), .c_rx_take(c_rx_take),
    .c_tx_word(c_tx_word), .c_tx_load(c_tx_load), .c_tx_free(c_tx_free)
  );

  function automatic logic [7:0] exp_status(bit rxf, bit txe, bit [1:0] fl, bit ovr);
    return 8'(rxf) + 8'(2 * txe) + 8'(4 * fl) + (ovr ? 8'h80 : 8'h00);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic host_cycle(input logic [1:0] sel, input bit wr, input logic [7:0] wd,
                            output logic [7:0] rd);
    @(negedge h_clk);
    h_sel = sel; h_wr = wr; h_rd = !wr; h_wdata = wd; h_en = 1;
    @(negedge h_clk); @(negedge h_clk);
    rd = h_rdata;
    @(negedge h_clk);
    h_en = 0; h_wr = 0; h_rd = 0;
    @(negedge h_clk); @(negedge h_clk);
  endtask

  task automatic status_triple(output logic [7:0] a, output logic [7:0] b, output logic [7:0] c);
    @(negedge h_clk);
    h_sel = 2'd0; h_rd = 1; h_en = 1;
    @(negedge h_clk); a = h_rdata;
    @(negedge h_clk); b = h_rdata;
    @(negedge h_clk); @(negedge h_clk); c = h_rdata;
    h_en = 0; h_rd = 0;
    @(negedge h_clk); @(negedge h_clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    forever begin
      @(negedge c_clk);
      if (flip_on) c_flags = ~c_flags;
    end
  end

  initial begin
    logic [7:0] rd, a, b, c;
    logic [15:0] w, w2;
    bit seen;
    void'($urandom(32'd4242));
    #33; h_rst_n = 1; c_rst_n = 1;
    repeat (4) @(negedge h_clk);

    // R1 reset state
    host_cycle(2'd0, 0, 8'h00, rd);
    chk("R1 status", rd, 8'h02);
    chk("R1 tx_free", c_tx_free, 1);
    chk("R1 rx_valid", c_rx_valid, 0);

    // host -> core words
    for (int i = 0; i < 12; i++) begin
      w = 16'($urandom);
      host_cycle(2'd1, 1, w[15:8], rd);
      host_cycle(2'd2, 1, w[7:0], rd);
      host_cycle(2'd0, 0, 8'h00, rd);
      chk("R3 txde cleared", rd & 8'h02, 0);
      if (i % 3 == 1) begin
        host_cycle(2'd1, 1, ~w[15:8], rd);
        host_cycle(2'd2, 1, ~w[7:0], rd);
        ovr_exp = 1;
      end
      host_cycle(2'd0, 0, 8'h00, rd);
      chk("R4 overrun bit", rd[7], ovr_exp);
      seen = 0;
      for (int k = 0; k < 60 && !seen; k++) begin
        @(negedge c_clk);
        seen = c_rx_valid;
      end
      chk("R3 rx_valid", seen, 1);
      chk("R3/R4 rx_word", c_rx_word, w);
      repeat (3) @(negedge c_clk);
      chk("R9 valid held", c_rx_valid, 1);
      chk("R9 word held", c_rx_word, w);
      c_rx_take = 1;
      @(negedge c_clk);
      c_rx_take = 0;
      seen = 0;
      for (int k = 0; k < 30 && !seen; k++) begin
        host_cycle(2'd0, 0, 8'h00, rd);
        seen = rd[1];
      end
      chk("R5 txde set", rd, exp_status(0, 1, 2'b00, ovr_exp));
    end

    // core -> host words
    for (int i = 0; i < 12; i++) begin
      w = 16'($urandom);
      w2 = ~w;
      @(negedge c_clk);
      c_tx_word = w; c_tx_load = 1;
      @(negedge c_clk);
      c_tx_load = 0;
      chk("R6 tx_free cleared", c_tx_free, 0);
      if (i % 2 == 0) begin
        c_tx_word = w2; c_tx_load = 1;
        @(negedge c_clk);
        c_tx_load = 0;
      end
      seen = 0;
      for (int k = 0; k < 30 && !seen; k++) begin
        host_cycle(2'd0, 0, 8'h00, rd);
        seen = rd[0];
      end
      chk("R6 rxdf", rd, exp_status(1, 1, 2'b00, ovr_exp));
      host_cycle(2'd1, 0, 8'h00, rd);
      chk("R6/R7 high byte", rd, w[15:8]);
      host_cycle(2'd2, 0, 8'h00, rd);
      chk("R6/R7 low byte", rd, w[7:0]);
      host_cycle(2'd0, 0, 8'h00, rd);
      chk("R7 rxdf cleared", rd & 8'h01, 0);
      seen = 0;
      for (int k = 0; k < 60 && !seen; k++) begin
        @(negedge c_clk);
        seen = c_tx_free;
      end
      chk("R7 tx_free back", seen, 1);
    end

    // R8 static pair 01 propagates whole
    @(negedge c_clk); c_flags = 2'b01;
    repeat (20) @(negedge h_clk);
    host_cycle(2'd0, 0, 8'h00, rd);
    chk("R8 static pair", rd, exp_status(0, 1, 2'b01, ovr_exp));
    @(negedge c_clk); c_flags = 2'b00;
    repeat (20) @(negedge h_clk);

    // R8 and R2 under a flag pair flipping every core cycle
    flip_on = 1;
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 0) begin
        status_triple(a, b, c);
        chk("R2 snapshot stable", {a, b}, {c, c});
        rd = a;
      end else begin
        host_cycle(2'd0, 0, 8'h00, rd);
      end
      chk("R8 pair coherent", (rd[3:2] == 2'b00 || rd[3:2] == 2'b11) ? 1 : 0, 1);
      chk("R2 other bits", rd & 8'h73, 8'h02);
      if ($urandom % 4 == 0) @(negedge c_clk);
    end
    flip_on = 0;

    finish_run();
  end
endmodule